// File: doc/BRIEF.md
# Multi-Channel Buffered DMA Engine

This block moves data between memory locations on behalf of software or on-chip peripherals. It has several independent channels, four by default. Each channel holds a source pointer, a destination pointer, a unit count, a control word and a completion flag. All channels share one master switch and one emergency-stop flag. Whenever a channel is allowed to run and has work pending, the engine grants it one unit. For that unit it reads from the source, keeps the returned word in an internal holding register, and then writes that word to the destination.

Software programs the channel through a flat register port. Each channel either runs freely (self-triggered) or waits for a level request from its peripheral. When the count runs out, the channel sets its completion flag and can raise its own interrupt line. The memory side is a single-outstanding master with separate read and write handshakes. Each request stays asserted until its acknowledge arrives.

Register map (`reg_addr`): bit 7 set selects the shared word (bit 0 master switch, bit 1 emergency stop). With bit 7 clear, bits 6:4 select the channel and bits 3:0 select the field: 0 source, 1 destination, 2 count, 3 control, 4 completion. Control bits: 0 run-enable, 1 peripheral-triggered (0 = self-triggered), 3:2 unit size code, 4 interrupt-enable. Completion bit 0 is the done flag.

Top module: `dma_engine`

## Requirements
- R1: A channel starts a unit only while its run-enable bit, the master switch (shared bit 0) and the inverted emergency-stop flag (shared bit 1) are all 1.
- R2: Among eligible channels the lowest-numbered one is granted. Grants happen only between units, so a channel that stays eligible keeps its turn ahead of higher-numbered channels.
- R3: A self-triggered channel (control bit 1 = 0) runs without any request. A peripheral-triggered channel (bit 1 = 1) starts a unit only while its `periph_req` bit is high.
- R4: Each unit is one read of the source followed by one write to the destination. The write data equals the full word returned by the read, and read and write are never requested together.
- R5: The size code in control bits 3:2 gives the unit size as 1, 2, 4 or 8 bytes for codes 0 to 3. It is driven on `ld_size`/`st_size`, and both pointers advance by the unit size after each unit.
- R6: The count decrements by one per completed unit. The unit that brings it to zero also clears the run-enable bit.
- R7: When a channel finishes, its done flag reads 1. Its `irq` bit rises in the same cycle if interrupt-enable (control bit 4) is 1, and stays low otherwise.
- R8: Writing 1 to completion bit 0 clears the done flag and drops that channel's `irq`.
- R9: Setting the emergency-stop flag during a unit lets that unit finish. No further unit starts until the flag is cleared, and the interrupted channel keeps its remaining count and enable.
- R10: A channel enabled with a count of zero finishes at once, without any memory access.
- R11: After reset, all registers read 0, no memory request is active and all `irq` bits are low.
- R12: An unacknowledged read or write request stays asserted with stable address and data until its acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| periph_req | input | NCH | Per-channel peripheral request levels |
| irq | output | NCH | Per-channel completion interrupts |
| ld_req | output | 1 | Memory read request |
| ld_addr | output | AW | Memory read address |
| ld_size | output | 2 | Memory read size code |
| ld_ack | input | 1 | Memory read acknowledge, data valid |
| ld_data | input | DW | Memory read data |
| st_req | output | 1 | Memory write request |
| st_addr | output | AW | Memory write address |
| st_size | output | 2 | Memory write size code |
| st_data | output | DW | Memory write data |
| st_ack | input | 1 | Memory write acknowledge |

## Verification
The assertions assume the memory side acknowledges only a pending request, with each acknowledge a single-cycle pulse. They also assume read data is valid in the acknowledge cycle. The bench's memory responder raises each acknowledge only after seeing the matching request for a fixed wait, and drops it on the next cycle. It drives read data as a fixed arithmetic function of the read address. Register writes are one-cycle strobes on falling edges. The emergency-stop write lands while a read is still waiting, which places it inside a unit.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [1:0] {
        MV_IDLE  = 2'd0,
        MV_LOAD  = 2'd1,
        MV_STORE = 2'd2
    } mv_state_t;

    // control word; packed order gives bit 0 = run, 1 = periph, 3:2 = size, 4 = irq enable
    typedef struct packed {
        logic       irq_en;
        logic [1:0] size;
        logic       periph;
        logic       run;
    } ctrl_t;

    localparam logic [3:0] FLD_SRC  = 4'd0;
    localparam logic [3:0] FLD_DST  = 4'd1;
    localparam logic [3:0] FLD_CNT  = 4'd2;
    localparam logic [3:0] FLD_CTRL = 4'd3;
    localparam logic [3:0] FLD_STAT = 4'd4;

    function automatic logic [3:0] unit_bytes(input logic [1:0] code);
        return 4'd1 << code;
    endfunction

endpackage

// File: rtl/dma_channel.sv
module dma_channel
    import dma_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [3:0]    wr_field,
    input  logic [31:0]   wr_data,
    input  logic          run_ok,
    input  logic          preq,
    input  logic          unit_done,
    output logic [AW-1:0] src,
    output logic [AW-1:0] dst,
    output logic [CW-1:0] cnt,
    output ctrl_t         ctrl,
    output logic          done,
    output logic          want
);

    logic          cnt_zero;
    logic          zero_end;
    logic [AW-1:0] step;

    assign cnt_zero = (cnt == '0);
    assign zero_end = ctrl.run && run_ok && cnt_zero;
    assign step     = AW'(unit_bytes(ctrl.size));
    assign want     = ctrl.run && run_ok && !cnt_zero && (!ctrl.periph || preq);

    always_ff @(posedge clk) begin
        if (rst) begin
            src  <= '0;
            dst  <= '0;
            cnt  <= '0;
            ctrl <= '0;
            done <= 1'b0;
        end else begin
            if (wr_en) begin
                case (wr_field)
                    FLD_SRC:  src  <= wr_data[AW-1:0];
                    FLD_DST:  dst  <= wr_data[AW-1:0];
                    FLD_CNT:  cnt  <= wr_data[CW-1:0];
                    FLD_CTRL: ctrl <= ctrl_t'(wr_data[4:0]);
                    FLD_STAT: if (wr_data[0]) done <= 1'b0;
                    default: ;
                endcase
            end
            if (unit_done) begin
                src <= src + step;
                dst <= dst + step;
                cnt <= cnt - CW'(1);
                if (cnt == CW'(1)) begin
                    done     <= 1'b1;
                    ctrl.run <= 1'b0;
                end
            end else if (zero_end) begin
                done     <= 1'b1;
                ctrl.run <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/dma_arbiter.sv
module dma_arbiter #(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0] want,
    output logic           any,
    output logic [CHW-1:0] idx
);

    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (want[i]) begin
                any = 1'b1;
                idx = CHW'(i);
            end
        end
    end

endmodule

// File: rtl/dma_mover.sv
module dma_mover
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 64,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [CHW-1:0] start_ch,
    input  logic [AW-1:0]  start_src,
    input  logic [AW-1:0]  start_dst,
    input  logic [1:0]     start_size,
    output logic           ld_req,
    output logic [AW-1:0]  ld_addr,
    output logic [1:0]     ld_size,
    input  logic           ld_ack,
    input  logic [DW-1:0]  ld_data,
    output logic           st_req,
    output logic [AW-1:0]  st_addr,
    output logic [1:0]     st_size,
    output logic [DW-1:0]  st_data,
    input  logic           st_ack,
    output logic           idle,
    output logic           fin,
    output logic [CHW-1:0] fin_ch
);

    mv_state_t      state;
    logic [CHW-1:0] cur_ch;
    logic [AW-1:0]  cur_src;
    logic [AW-1:0]  cur_dst;
    logic [1:0]     cur_size;
    logic [DW-1:0]  hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= MV_IDLE;
            cur_ch   <= '0;
            cur_src  <= '0;
            cur_dst  <= '0;
            cur_size <= '0;
            hold     <= '0;
        end else begin
            case (state)
                MV_IDLE: if (start) begin
                    cur_ch   <= start_ch;
                    cur_src  <= start_src;
                    cur_dst  <= start_dst;
                    cur_size <= start_size;
                    state    <= MV_LOAD;
                end
                MV_LOAD: if (ld_ack) begin
                    hold  <= ld_data;
                    state <= MV_STORE;
                end
                MV_STORE: if (st_ack) state <= MV_IDLE;
                default: state <= MV_IDLE;
            endcase
        end
    end

    assign idle    = (state == MV_IDLE);
    assign ld_req  = (state == MV_LOAD);
    assign st_req  = (state == MV_STORE);
    assign ld_addr = cur_src;
    assign st_addr = cur_dst;
    assign ld_size = cur_size;
    assign st_size = cur_size;
    assign st_data = hold;
    assign fin     = st_req && st_ack;
    assign fin_ch  = cur_ch;

endmodule

// File: rtl/dma_engine.sv
module dma_engine
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 32,
    parameter int DW  = 64,
    parameter int CW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           reg_wr,
    input  logic [7:0]     reg_addr,
    input  logic [31:0]    reg_wdata,
    output logic [31:0]    reg_rdata,
    input  logic [NCH-1:0] periph_req,
    output logic [NCH-1:0] irq,
    output logic           ld_req,
    output logic [AW-1:0]  ld_addr,
    output logic [1:0]     ld_size,
    input  logic           ld_ack,
    input  logic [DW-1:0]  ld_data,
    output logic           st_req,
    output logic [AW-1:0]  st_addr,
    output logic [1:0]     st_size,
    output logic [DW-1:0]  st_data,
    input  logic           st_ack
);

    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

    logic           master_en;
    logic           nmi_flag;
    logic           run_ok;
    logic [2:0]     sel_raw;
    logic [CHW-1:0] sel_ch;
    logic           sel_ok;

    logic [AW-1:0]  src_a  [NCH];
    logic [AW-1:0]  dst_a  [NCH];
    logic [CW-1:0]  cnt_a  [NCH];
    ctrl_t          ctrl_a [NCH];
    logic [NCH-1:0] done_v;
    logic [NCH-1:0] want_v;

    logic           arb_any;
    logic [CHW-1:0] arb_idx;
    logic           mv_idle;
    logic           mv_fin;
    logic [CHW-1:0] mv_fin_ch;

    assign run_ok  = master_en && !nmi_flag;
    assign sel_raw = reg_addr[6:4];
    assign sel_ch  = sel_raw[CHW-1:0];
    assign sel_ok  = ({1'b0, sel_raw} < 4'(NCH));

    always_ff @(posedge clk) begin
        if (rst) begin
            master_en <= 1'b0;
            nmi_flag  <= 1'b0;
        end else if (reg_wr && reg_addr[7]) begin
            master_en <= reg_wdata[0];
            nmi_flag  <= reg_wdata[1];
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_channel #(.AW(AW), .CW(CW)) u_ch (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (reg_wr && !reg_addr[7] && (sel_raw == 3'(g))),
            .wr_field (reg_addr[3:0]),
            .wr_data  (reg_wdata),
            .run_ok   (run_ok),
            .preq     (periph_req[g]),
            .unit_done(mv_fin && (mv_fin_ch == CHW'(g))),
            .src      (src_a[g]),
            .dst      (dst_a[g]),
            .cnt      (cnt_a[g]),
            .ctrl     (ctrl_a[g]),
            .done     (done_v[g]),
            .want     (want_v[g])
        );
        assign irq[g] = done_v[g] && ctrl_a[g].irq_en;
    end

    dma_arbiter #(.NCH(NCH)) u_arb (
        .want(want_v),
        .any (arb_any),
        .idx (arb_idx)
    );

    dma_mover #(.NCH(NCH), .AW(AW), .DW(DW)) u_mv (
        .clk       (clk),
        .rst       (rst),
        .start     (arb_any),
        .start_ch  (arb_idx),
        .start_src (src_a[arb_idx]),
        .start_dst (dst_a[arb_idx]),
        .start_size(ctrl_a[arb_idx].size),
        .ld_req    (ld_req),
        .ld_addr   (ld_addr),
        .ld_size   (ld_size),
        .ld_ack    (ld_ack),
        .ld_data   (ld_data),
        .st_req    (st_req),
        .st_addr   (st_addr),
        .st_size   (st_size),
        .st_data   (st_data),
        .st_ack    (st_ack),
        .idle      (mv_idle),
        .fin       (mv_fin),
        .fin_ch    (mv_fin_ch)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr[7]) begin
            reg_rdata = {30'd0, nmi_flag, master_en};
        end else if (sel_ok) begin
            case (reg_addr[3:0])
                FLD_SRC:  reg_rdata = 32'(src_a[sel_ch]);
                FLD_DST:  reg_rdata = 32'(dst_a[sel_ch]);
                FLD_CNT:  reg_rdata = 32'(cnt_a[sel_ch]);
                FLD_CTRL: reg_rdata = {27'd0, ctrl_a[sel_ch]};
                FLD_STAT: reg_rdata = {31'd0, done_v[sel_ch]};
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/dma_engine_chk.sv
module dma_engine_chk #(
    parameter int AW = 32,
    parameter int DW = 64
) (
    input logic          clk,
    input logic          rst,
    input logic          master_en,
    input logic          nmi_flag,
    input logic          ld_req,
    input logic          ld_ack,
    input logic [AW-1:0] ld_addr,
    input logic [DW-1:0] ld_data,
    input logic          st_req,
    input logic          st_ack,
    input logic [AW-1:0] st_addr,
    input logic [DW-1:0] st_data
);

    assert_gate_R1: assert property (@(posedge clk) disable iff (rst)
        $rose(ld_req) |-> $past(master_en && !nmi_flag));

    assert_excl_R4: assert property (@(posedge clk) disable iff (rst)
        !(ld_req && st_req));

    assert_order_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(st_req) |-> $past(ld_req && ld_ack));

    assert_data_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(st_req) |-> (st_data == $past(ld_data)));

    assert_ld_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (ld_req && !ld_ack) |=> (ld_req && $stable(ld_addr)));

    assert_st_hold_R12: assert property (@(posedge clk) disable iff (rst)
        (st_req && !st_ack) |=> (st_req && $stable(st_addr) && $stable(st_data)));

    assert_halt_R9: assert property (@(posedge clk) disable iff (rst)
        (nmi_flag && !ld_req && !st_req) |=> !ld_req);

endmodule

bind dma_engine dma_engine_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .master_en(master_en),
    .nmi_flag (nmi_flag),
    .ld_req   (ld_req),
    .ld_ack   (ld_ack),
    .ld_addr  (ld_addr),
    .ld_data  (ld_data),
    .st_req   (st_req),
    .st_ack   (st_ack),
    .st_addr  (st_addr),
    .st_data  (st_data)
);

// File: tb/dma_engine_tb.sv
module dma_engine_tb;

    localparam int NCH = 4;
    localparam int LAT = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           reg_wr = 1'b0;
    logic [7:0]     reg_addr = '0;
    logic [31:0]    reg_wdata = '0;
    logic [31:0]    reg_rdata;
    logic [NCH-1:0] periph_req = '0;
    logic [NCH-1:0] irq;
    logic           ld_req, st_req;
    logic [31:0]    ld_addr, st_addr;
    logic [1:0]     ld_size, st_size;
    logic           ld_ack = 1'b0, st_ack = 1'b0;
    logic [63:0]    ld_data = '0, st_data;

    int n_chk = 0, n_bad = 0, n_ld = 0, n_st = 0;
    logic [31:0] log_addr [64];
    logic [63:0] log_data [64];
    logic [1:0]  log_size [64];

    always #5 clk = ~clk;

    dma_engine #(.NCH(NCH)) u_dut (.*);

    function automatic logic [63:0] mem_fn(input logic [31:0] a);
        return {a ^ 32'hA5A5_0F0F, a + 32'h1357};
    endfunction

    function automatic logic [7:0] ra(input int ch, input int f);
        return {1'b0, 3'(ch), 4'(f)};
    endfunction

    // memory responder
    initial begin
        int lw = 0, sw = 0;
        forever begin
            @(negedge clk);
            if (ld_ack) ld_ack = 1'b0;
            else if (ld_req) begin
                if (lw >= LAT) begin
                    ld_ack = 1'b1; ld_data = mem_fn(ld_addr); n_ld++; lw = 0;
                end else lw++;
            end
            if (st_ack) st_ack = 1'b0;
            else if (st_req) begin
                if (sw >= LAT) begin
                    st_ack = 1'b1;
                    if (n_st < 64) begin
                        log_addr[n_st] = st_addr; log_data[n_st] = st_data; log_size[n_st] = st_size;
                    end
                    n_st++; sw = 0;
                end else sw++;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_irq(input int ch);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (irq[ch]) break;
        end
    endtask

    task automatic finish_run;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 reset state
        chk(irq == 0 && !ld_req && !st_req, "R11", {irq, ld_req, st_req}, 0);
        rd(8'h80, v); chk(v == 0, "R11 common", v, 0);
        rd(ra(0, 3), v); chk(v == 0, "R11 ctrl", v, 0);
        rd(ra(2, 2), v); chk(v == 0, "R11 count", v, 0);

        // sweep: channel x size x count, self-triggered (R4 R5 R6 R7 R8)
        wr(8'h80, 32'h1);
        for (int ch = 0; ch < NCH; ch++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int n = 1; n <= 2; n++) begin
                    logic [31:0] s0, d0, b;
                    s0 = 32'h1000 * (ch + 1) + 32'(sz * 16 + n);
                    d0 = 32'h8000 + 32'h100 * 32'(ch) + 32'(sz * 32);
                    b  = 32'd1 << sz;
                    n_st = 0;
                    wr(ra(ch, 0), s0); wr(ra(ch, 1), d0); wr(ra(ch, 2), 32'(n));
                    wr(ra(ch, 3), 32'h11 | 32'(sz << 2));
                    wait_irq(ch);
                    chk(irq[ch] == 1'b1, "R7 irq", 64'(irq), 64'(1 << ch));
                    chk(n_st == n, "R4 store count", 64'(n_st), 64'(n));
                    for (int k = 0; k < n; k++) begin
                        chk(log_addr[k] == d0 + 32'(k) * b, "R5 dst addr", log_addr[k], d0 + 32'(k) * b);
                        chk(log_data[k] == mem_fn(s0 + 32'(k) * b), "R4 data", log_data[k], mem_fn(s0 + 32'(k) * b));
                        chk(log_size[k] == 2'(sz), "R5 size", log_size[k], 64'(sz));
                    end
                    rd(ra(ch, 2), v); chk(v == 0, "R6 count", v, 0);
                    rd(ra(ch, 3), v); chk(v[0] == 1'b0, "R6 run cleared", v, 32'(v & ~32'h1));
                    rd(ra(ch, 0), v); chk(v == s0 + 32'(n) * b, "R5 src adv", v, s0 + 32'(n) * b);
                    rd(ra(ch, 4), v); chk(v == 1, "R7 done", v, 1);
                    wr(ra(ch, 4), 32'h1);
                    @(negedge clk);
                    chk(irq[ch] == 1'b0, "R8 irq clr", 64'(irq), 0);
                    rd(ra(ch, 4), v); chk(v == 0, "R8 done clr", v, 0);
                end
            end
        end

        // R2 priority: ch2 and ch1 enabled together
        wr(8'h80, 32'h0);
        n_st = 0;
        wr(ra(2, 0), 32'h2000); wr(ra(2, 1), 32'hB000); wr(ra(2, 2), 2); wr(ra(2, 3), 32'h11);
        wr(ra(1, 0), 32'h1000); wr(ra(1, 1), 32'hA000); wr(ra(1, 2), 2); wr(ra(1, 3), 32'h11);
        wr(8'h80, 32'h1);
        wait_irq(2);
        chk(n_st == 4, "R2 total", 64'(n_st), 4);
        chk(log_addr[0] == 32'hA000 && log_addr[1] == 32'hA001, "R2 ch1 first", log_addr[1], 32'hA001);
        chk(log_addr[2] == 32'hB000 && log_addr[3] == 32'hB001, "R2 ch2 after", log_addr[3], 32'hB001);
        wr(ra(1, 4), 1); wr(ra(2, 4), 1);

        // R1 gating: emergency stop held while channel enabled
        n_ld = 0; n_st = 0;
        wr(8'h80, 32'h3);
        wr(ra(0, 0), 32'h40); wr(ra(0, 1), 32'h4000); wr(ra(0, 2), 1); wr(ra(0, 3), 32'h11);
        repeat (20) @(negedge clk);
        chk(n_ld == 0, "R1 stop gates", 64'(n_ld), 0);
        wr(8'h80, 32'h0);
        repeat (20) @(negedge clk);
        chk(n_ld == 0, "R1 master gates", 64'(n_ld), 0);
        wr(8'h80, 32'h1);
        wait_irq(0);
        chk(n_st == 1, "R1 runs when open", 64'(n_st), 1);
        wr(ra(0, 4), 1);

        // R3 peripheral-triggered channel
        n_st = 0;
        wr(ra(3, 0), 32'h300); wr(ra(3, 1), 32'h5000); wr(ra(3, 2), 2); wr(ra(3, 3), 32'h13);
        repeat (20) @(negedge clk);
        chk(n_st == 0, "R3 waits for request", 64'(n_st), 0);
        rd(ra(3, 2), v); chk(v == 2, "R3 count kept", v, 2);
        periph_req[3] = 1'b1;
        wait_irq(3);
        periph_req[3] = 1'b0;
        chk(n_st == 2, "R3 runs on request", 64'(n_st), 2);
        wr(ra(3, 4), 1);

        // R9 emergency stop during a unit
        n_st = 0;
        wr(ra(0, 0), 32'h600); wr(ra(0, 1), 32'h6000); wr(ra(0, 2), 3); wr(ra(0, 3), 32'h11);
        for (int i = 0; i < 50; i++) begin
            if (ld_req) break;
            @(negedge clk);
        end
        wr(8'h80, 32'h3);
        repeat (40) @(negedge clk);
        chk(n_st == 1, "R9 unit finished", 64'(n_st), 1);
        rd(ra(0, 2), v); chk(v == 2, "R9 count kept", v, 2);
        rd(ra(0, 3), v); chk(v[0] == 1'b1, "R9 run kept", v, 32'h11);
        wr(8'h80, 32'h1);
        wait_irq(0);
        chk(n_st == 3, "R9 resumes", 64'(n_st), 3);
        wr(ra(0, 4), 1);

        // R10 zero count
        n_ld = 0;
        wr(ra(1, 2), 0); wr(ra(1, 3), 32'h11);
        wait_irq(1);
        chk(irq[1] == 1'b1, "R10 ends", 64'(irq), 2);
        chk(n_ld == 0, "R10 no access", 64'(n_ld), 0);
        rd(ra(1, 3), v); chk(v[0] == 1'b0, "R10 run cleared", v, 32'h10);
        wr(ra(1, 4), 1);

        // R7 interrupt disabled
        n_st = 0;
        wr(ra(2, 2), 1); wr(ra(2, 3), 32'h01);
        repeat (30) @(negedge clk);
        chk(n_st == 1, "R7 moved", 64'(n_st), 1);
        chk(irq[2] == 1'b0, "R7 irq masked", 64'(irq), 0);
        rd(ra(2, 4), v); chk(v == 1, "R7 done w/o irq", v, 1);

        finish_run();
    end

endmodule